// File: doc/BRIEF.md
# Transmit Jabber Guard with Post-Transmit Collision Test Pulse

This block sits between a 10 Mb/s Ethernet MAC and its transmit path. It times every transmission. A transmission that runs too long is cut off: the block enters a lockout that blocks transmit and loopback, and it reports collision and carrier toward the controller. The lockout ends only after transmit enable has stayed released for a fixed recovery interval. After a transmission that ends normally, the block sends a single collision pulse of fixed delay and width to the controller, as a signal-quality test. This pulse is not sent in full duplex or during link failure. All limits are parameters counted in clock cycles. The defaults assume a 20 MHz clock: 50 ms jabber limit, 415 ms recovery, 650 ns pulse delay and 800 ns pulse width.

The controller-type select sets the polarity of the interface. When it is 0, transmit enable, collision and carrier force are active high. When it is 1, all three are active low. The raw enable is converted to active-high first. It then passes through a two-stage synchronizer, and only after that does any timer logic see it.

The state machine has six states:
- ST_IDLE goes to ST_XMIT when enable is seen.
- ST_XMIT goes to ST_SQE_WAIT on release. It goes to ST_IDLE instead on release if full duplex or link-fail is active. It goes to ST_JABBER when the jabber limit expires.
- ST_SQE_WAIT goes to ST_SQE_PULSE after the delay. It goes to ST_IDLE if full duplex or link-fail appears. It goes to ST_XMIT on a new enable.
- ST_SQE_PULSE goes to ST_IDLE after the width, or when full duplex or link-fail appears. It goes to ST_XMIT on a new enable.
- ST_JABBER goes to ST_UNJAB on release.
- ST_UNJAB goes to ST_IDLE after the recovery interval. It goes back to ST_JABBER if enable returns.

Top module: `jabber_sqe_guard`

## Requirements
In the requirements below, E0 is the first rising edge at which raw enable is at its active level. L is the number of consecutive edges for which it is held active. "Active" on col_out and crs_force means the level equal to the inverse of ctl_sel.
- R1: After reset, tx_block is 0 and col_out and crs_force are inactive.
- R2: With ctl_sel=1, tx_en_raw, col_out and crs_force are active low. With ctl_sel=0, they are active high. Timing is otherwise identical in both modes.
- R3: The jabber lockout is entered only when L > JAB_LIMIT. In that case tx_block rises just after edge E(JAB_LIMIT+2). With L = JAB_LIMIT, no lockout occurs.
- R4: Releasing enable before the limit restarts the timer. Consecutive transmissions each up to JAB_LIMIT edges long, with short gaps between them, never cause a lockout.
- R5: While tx_block is 1, crs_force is active. col_out is also active unless fdx_active is 1.
- R6: After a lockout, tx_block falls just after edge E(L+2+UNJAB_CYCLES).
- R7: If enable returns during recovery, the lockout is re-entered. A full recovery interval then restarts from the next release.
- R8: When L ≤ JAB_LIMIT, col_out is active from just after edge E(L+2+SQE_DELAY) for exactly SQE_WIDTH cycles. Otherwise it is inactive.
- R9: No test pulse is produced after a transmission that ended in lockout, nor while link_fail is 1.
- R10: While fdx_active is 1, col_out is never active. This covers both the test pulse and the lockout.
- R11: A new transmission that starts before the test pulse ends cancels that pulse. Timing then restarts for the new transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 20 MHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en_raw | input | 1 | Transmit enable from the controller, polarity set by ctl_sel |
| ctl_sel | input | 1 | Controller type: 0 active-high interface, 1 active-low |
| fdx_active | input | 1 | Full duplex in effect (active high) |
| link_fail | input | 1 | Link failure in effect (active high) |
| tx_block | output | 1 | Inhibits transmit and loopback (active high) |
| col_out | output | 1 | Collision toward the controller, polarity set by ctl_sel |
| crs_force | output | 1 | Forces carrier sense toward the controller, polarity set by ctl_sel |

## Verification
The assertions check properties that hold on every cycle:
- collision and carrier accompany the lockout;
- collision stays silent under full duplex or sustained link-fail;
- the test pulse never exceeds its width;
- the enable level sampled three edges earlier is consistent with each rise and fall of tx_block.

Only the bench scenarios can show the exact cycles at which the lockout begins, at which recovery ends and at which the pulse appears. The same holds for the L = JAB_LIMIT boundary, for re-entry from recovery and for cancellation of a pending pulse. The bench compares every cycle of each transmission against windows computed from L.

// File: rtl/jsg_pkg.sv
package jsg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XMIT,
        ST_SQE_WAIT,
        ST_SQE_PULSE,
        ST_JABBER,
        ST_UNJAB
    } jsg_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/jsg_sync.sv
module jsg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[STAGES-2:0], d};
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/jsg_counter.sv
module jsg_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/jsg_fsm.sv
module jsg_fsm
    import jsg_pkg::*;
#(
    parameter int JAB_LIMIT    = 1_000_000,
    parameter int UNJAB_CYCLES = 8_300_000,
    parameter int SQE_DELAY    = 13,
    parameter int SQE_WIDTH    = 16,
    parameter int CW           = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_act,
    input  logic          fdx,
    input  logic          lf,
    input  logic [CW-1:0] cnt,
    output logic          state_chg,
    output logic          inhibit,
    output logic          col_i,
    output logic          crs_i
);
    localparam logic [CW-1:0] JAB_LAST = CW'(JAB_LIMIT - 1);
    localparam logic [CW-1:0] UNJ_LAST = CW'(UNJAB_CYCLES - 1);
    localparam logic [CW-1:0] DLY_LAST = CW'(SQE_DELAY - 1);
    localparam logic [CW-1:0] WID_LAST = CW'(SQE_WIDTH - 1);

    jsg_state_e state, state_n;
    logic       sqe_block;

    assign sqe_block = fdx | lf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (tx_act) state_n = ST_XMIT;
            end
            ST_XMIT: begin
                if (!tx_act)                state_n = sqe_block ? ST_IDLE : ST_SQE_WAIT;
                else if (cnt == JAB_LAST)   state_n = ST_JABBER;
            end
            ST_SQE_WAIT: begin
                if (tx_act)                 state_n = ST_XMIT;
                else if (sqe_block)         state_n = ST_IDLE;
                else if (cnt == DLY_LAST)   state_n = ST_SQE_PULSE;
            end
            ST_SQE_PULSE: begin
                if (tx_act)                 state_n = ST_XMIT;
                else if (sqe_block)         state_n = ST_IDLE;
                else if (cnt == WID_LAST)   state_n = ST_IDLE;
            end
            ST_JABBER: begin
                if (!tx_act) state_n = ST_UNJAB;
            end
            ST_UNJAB: begin
                if (tx_act)                 state_n = ST_JABBER;
                else if (cnt == UNJ_LAST)   state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    assign state_chg = (state_n != state);

    always_comb begin
        inhibit = 1'b0;
        col_i   = 1'b0;
        crs_i   = 1'b0;
        unique case (state)
            ST_JABBER, ST_UNJAB: begin
                inhibit = 1'b1;
                crs_i   = 1'b1;
                col_i   = !fdx;
            end
            ST_SQE_PULSE: begin
                col_i = !fdx;
            end
            default: begin
                inhibit = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/jabber_sqe_guard.sv
module jabber_sqe_guard
    import jsg_pkg::*;
#(
    parameter int JAB_LIMIT    = 1_000_000,
    parameter int UNJAB_CYCLES = 8_300_000,
    parameter int SQE_DELAY    = 13,
    parameter int SQE_WIDTH    = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en_raw,
    input  logic ctl_sel,
    input  logic fdx_active,
    input  logic link_fail,
    output logic tx_block,
    output logic col_out,
    output logic crs_force
);
    localparam int MAXL = max2(max2(JAB_LIMIT, UNJAB_CYCLES), max2(SQE_DELAY, SQE_WIDTH));
    localparam int CW   = $clog2(MAXL + 1) + 1;

    logic          tx_norm;
    logic          tx_act;
    logic          state_chg;
    logic [CW-1:0] cnt;
    logic          col_i;
    logic          crs_i;

    assign tx_norm = tx_en_raw ^ ctl_sel;

    jsg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (tx_norm),
        .q     (tx_act)
    );

    jsg_counter #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_chg),
        .cnt   (cnt)
    );

    jsg_fsm #(
        .JAB_LIMIT    (JAB_LIMIT),
        .UNJAB_CYCLES (UNJAB_CYCLES),
        .SQE_DELAY    (SQE_DELAY),
        .SQE_WIDTH    (SQE_WIDTH),
        .CW           (CW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_act    (tx_act),
        .fdx       (fdx_active),
        .lf        (link_fail),
        .cnt       (cnt),
        .state_chg (state_chg),
        .inhibit   (tx_block),
        .col_i     (col_i),
        .crs_i     (crs_i)
    );

    assign col_out   = col_i ^ ctl_sel;
    assign crs_force = crs_i ^ ctl_sel;
endmodule

// File: rtl/jsg_checker.sv
module jsg_checker #(
    parameter int SQE_WIDTH = 16
) (
    input logic clk,
    input logic rst_n,
    input logic tx_en_raw,
    input logic ctl_sel,
    input logic fdx_active,
    input logic link_fail,
    input logic tx_block,
    input logic col_out,
    input logic crs_force
);
    logic        act;
    logic        col_act;
    logic        crs_act;
    int unsigned run_len;

    assign act     = tx_en_raw ^ ctl_sel;
    assign col_act = col_out ^ ctl_sel;
    assign crs_act = crs_force ^ ctl_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= 0;
        end else if (col_act && !tx_block) begin
            run_len <= run_len + 1;
        end else begin
            run_len <= 0;
        end
    end

    // R5
    jab_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_block |-> (crs_act && (col_act || fdx_active)));

    // R10
    fdx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fdx_active |-> !col_act);

    // R9
    lf_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_fail && $past(link_fail) && !tx_block) |-> !col_act);

    // R8
    sqe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_act && !tx_block) |-> (run_len < SQE_WIDTH));

    // R3
    jab_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_block) |-> $past(act, 3));

    // R6
    unjab_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_block) |-> !$past(act, 3));
endmodule

bind jabber_sqe_guard jsg_checker #(.SQE_WIDTH(SQE_WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en_raw  (tx_en_raw),
    .ctl_sel    (ctl_sel),
    .fdx_active (fdx_active),
    .link_fail  (link_fail),
    .tx_block   (tx_block),
    .col_out    (col_out),
    .crs_force  (crs_force)
);

// File: tb/sim_jabber_sqe_guard.sv
`timescale 1ns/1ps
module sim_jabber_sqe_guard;
    localparam int P_JAB = 40;
    localparam int P_UNJ = 60;
    localparam int P_DLY = 13;
    localparam int P_WID = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en_raw = 1'b0;
    logic ctl_sel = 1'b0;
    logic fdx_active = 1'b0;
    logic link_fail = 1'b0;
    logic tx_block, col_out, crs_force;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    jabber_sqe_guard #(
        .JAB_LIMIT(P_JAB), .UNJAB_CYCLES(P_UNJ),
        .SQE_DELAY(P_DLY), .SQE_WIDTH(P_WID)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .tx_en_raw(tx_en_raw), .ctl_sel(ctl_sel),
        .fdx_active(fdx_active), .link_fail(link_fail),
        .tx_block(tx_block), .col_out(col_out), .crs_force(crs_force)
    );

    task automatic chk(input logic got, input logic exp, input string tag,
                       input string what, input int k);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s step %0d: got %0b expected %0b", tag, what, k, got, exp);
        end
    endtask

    function automatic bit e_inh(input int k, input int len);
        return (len > P_JAB) && (k >= P_JAB + 3) && (k <= len + 2 + P_UNJ);
    endfunction

    function automatic bit e_col(input int k, input int len, input bit fd, input bit lfl);
        if (len > P_JAB) return e_inh(k, len) && !fd;
        return !fd && !lfl && (k >= len + 3 + P_DLY) && (k <= len + 2 + P_DLY + P_WID);
    endfunction

    task automatic do_reset(input bit sel);
        @(negedge clk);
        rst_n = 1'b0; ctl_sel = sel; tx_en_raw = sel;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_block, 1'b0, "R1", "tx_block", 0);
        chk(col_out, sel, "R1 R2", "col_out", 0);
        chk(crs_force, sel, "R1 R2", "crs_force", 0);
    endtask

    task automatic set_sel(input bit sel);
        @(negedge clk);
        ctl_sel = sel; tx_en_raw = sel;
    endtask

    task automatic run_tx(input int len, input bit fd, input bit lfl, input string tag);
        int total;
        total = len + 2 + ((P_DLY + P_WID > P_UNJ) ? P_DLY + P_WID : P_UNJ) + 4;
        @(negedge clk);
        fdx_active = fd; link_fail = lfl;
        tx_en_raw = ~ctl_sel;
        for (int k = 1; k <= total; k++) begin
            @(negedge clk);
            chk(tx_block, e_inh(k, len), tag, "tx_block", k);
            chk(col_out, e_col(k, len, fd, lfl) ^ ctl_sel, tag, "col_out", k);
            chk(crs_force, e_inh(k, len) ^ ctl_sel, tag, "crs_force", k);
            if (k == len) tx_en_raw = ctl_sel;
        end
        fdx_active = 1'b0; link_fail = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        do_reset(1'b0);

        run_tx(20, 1'b0, 1'b0, "R8 normal");
        run_tx(P_JAB, 1'b0, 1'b0, "R3 R8 limit");
        run_tx(P_JAB + 1, 1'b0, 1'b0, "R3 R5 R6 jabber");
        run_tx(20, 1'b1, 1'b0, "R10 fdx");
        run_tx(P_JAB + 8, 1'b1, 1'b0, "R10 R5 fdx jabber");
        run_tx(20, 1'b0, 1'b1, "R9 linkfail");
        run_tx(P_JAB + 8, 1'b0, 1'b0, "R9 R6 after jabber");

        // R4: two back-to-back transmissions at the limit
        @(negedge clk);
        tx_en_raw = ~ctl_sel;
        for (int k = 1; k <= 2 * P_JAB + 45; k++) begin
            @(negedge clk);
            chk(tx_block, 1'b0, "R4", "tx_block", k);
            if (k == P_JAB) tx_en_raw = ctl_sel;
            if (k == P_JAB + 3) tx_en_raw = ~ctl_sel;
            if (k == 2 * P_JAB + 3) tx_en_raw = ctl_sel;
        end

        // R11: new transmission during the pulse delay cancels it
        @(negedge clk);
        tx_en_raw = ~ctl_sel;
        for (int k = 1; k <= 70; k++) begin
            @(negedge clk);
            if (k == 26) chk(col_out, ctl_sel, "R11", "col_out cancelled", k);
            if (k == 41) chk(col_out, ~ctl_sel, "R11", "col_out restart", k);
            if (k == 56) chk(col_out, ~ctl_sel, "R11", "col_out last", k);
            if (k == 57) chk(col_out, ctl_sel, "R11", "col_out end", k);
            if (k == 10) tx_en_raw = ctl_sel;
            if (k == 15) tx_en_raw = ~ctl_sel;
            if (k == 25) tx_en_raw = ctl_sel;
        end

        // R7: enable returns during recovery
        begin
            int len;
            len = P_JAB + 5;
            @(negedge clk);
            tx_en_raw = ~ctl_sel;
            for (int k = 1; k <= len + 20 + P_UNJ + P_DLY + P_WID; k++) begin
                @(negedge clk);
                if (k == len + 3 + P_UNJ)  chk(tx_block, 1'b1, "R7", "tx_block held", k);
                if (k == len + 15 + P_UNJ) chk(tx_block, 1'b1, "R7", "tx_block last", k);
                if (k == len + 16 + P_UNJ) chk(tx_block, 1'b0, "R7", "tx_block end", k);
                if (k >= len + 16 + P_UNJ) chk(col_out, ctl_sel, "R9", "col_out no pulse", k);
                if (k == len)      tx_en_raw = ctl_sel;
                if (k == len + 10) tx_en_raw = ~ctl_sel;
                if (k == len + 13) tx_en_raw = ctl_sel;
            end
        end

        do_reset(1'b1);
        run_tx(20, 1'b0, 1'b0, "R2 R8 active-low");
        run_tx(P_JAB + 3, 1'b0, 1'b0, "R2 R3 R5 active-low");

        for (int i = 0; i < 30; i++) begin
            set_sel(1'($urandom % 2));
            run_tx(1 + int'($urandom % (P_JAB + 20)),
                   ($urandom % 4) == 0, ($urandom % 4) == 0, "R3 R8 R9 R10 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule